// File: doc/BRIEF.md
# Burst Address Counter with Interleaved and Linear Order

This block supplies the word address for a four-beat burst into a synchronous memory. When a new access starts, it takes in a full 15-bit address from outside. That address is presented for the first beat. After that, only the two lowest bits move, and the upper bits keep the captured value.

The order of the two low bits comes from a static mode input. Interleaved order flips bits of the start value by XOR with the beat number. Linear order counts upward modulo four inside the aligned group of four words. On every clock the counter does one of three things: it reloads, it advances, or it holds to insert a wait state. A 2-bit beat index counts the advances since the last load.

Top module: `burst_addr_counter`

## Requirements
- R1: A clock edge with `rst_n` low clears the stored address and the beat index, so that `acc_addr` reads 0 and `beat_idx` reads 0 after that edge.
- R2: A clock edge with `start_req` high captures all 15 bits of `ext_addr`. After that edge `acc_addr` equals the captured address and `beat_idx` is 0.
- R3: Between loads, bits 14 down to 2 of `acc_addr` keep the value captured at the last load.
- R4: With `ilv_mode` = 1 (interleaved), `acc_addr[1:0]` equals the captured low bits XOR `beat_idx`. For example, a start of 01 gives 01, 00, 11, 10.
- R5: With `ilv_mode` = 0 (linear), `acc_addr[1:0]` equals the captured low bits plus `beat_idx`, modulo 4. For example, a start of 10 gives 10, 11, 00, 01.
- R6: A clock edge with `start_req` low and `adv_n` low increments `beat_idx` by one, modulo 4. After the fourth advance the address is back to the first address of the burst.
- R7: A clock edge with `start_req` low and `adv_n` high leaves `acc_addr` and `beat_idx` unchanged (wait state).
- R8: A load takes priority over an advance. With `start_req` high and `adv_n` low at the same edge, the new address is taken and `beat_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_req | input | 1 | Load strobe, active high; starts a new burst from `ext_addr` |
| adv_n | input | 1 | Advance strobe, active low; high inserts a wait state |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear; treated as static |
| ext_addr | input | 15 | External start address |
| acc_addr | output | 15 | Address of the current access |
| beat_idx | output | 2 | Number of advances since the last load, modulo 4 |

## Verification
The bench checks the odd start offsets, 01 and 11. At those offsets the two orders differ, so a design that used a sum in interleaved mode, or an XOR in linear mode, would produce the wrong second address. Long advance runs check the wrap after the fourth beat. A design that let the carry reach bit 2, or that stopped at beat 3, would change the upper address or stall there. Loads with `adv_n` low at the same edge check priority: a design that favoured the advance would start the new burst at beat 1. Wait states placed between advances check that a held cycle moves neither the address nor the index.

// File: rtl/bac_pkg.sv
`timescale 1ns/1ps
// Package for the burst address counter.
// Holds the burst order encoding shared by the top and the sequence mapper.
package bac_pkg;
    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;
endpackage

// File: rtl/bac_addr_reg.sv
`timescale 1ns/1ps
// Start address register.
// Captures the full external address on a load. The upper part is kept as
// the fixed burst base; the low part is kept as the start offset.
// Assumes: reset is synchronous, active low, and ADDR_W > BEAT_W.
module bac_addr_reg #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned BEAT_W = 2,
    localparam int unsigned HI_W  = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [HI_W-1:0]   base_hi,
    output logic [BEAT_W-1:0] start_lo
);
    // Capture the base and the start offset on a load; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi  <= '0;
            start_lo <= '0;
        end else if (load) begin
            base_hi  <= ext_addr[ADDR_W-1:BEAT_W];
            start_lo <= ext_addr[BEAT_W-1:0];
        end
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ({base_hi, start_lo} == $past(ext_addr))); // R2
    AST_BASE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(base_hi)); // R3
endmodule

// File: rtl/bac_beat_ctr.sv
`timescale 1ns/1ps
// Beat counter.
// Counts advances since the last load, modulo 2**BEAT_W. A load clears the
// count and takes priority over an advance. With no advance, the count holds.
// Assumes: reset is synchronous, active low.
module bac_beat_ctr #(
    parameter int unsigned BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv_n,
    output logic [BEAT_W-1:0] beat
);
    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

    // Clear on reset or load; step on an advance; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (load) begin
            beat <= '0;
        end else if (!adv_n) begin
            beat <= beat + ONE;
        end
    end

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n) |=> (beat == $past(beat) + ONE)); // R6
    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n) |=> $stable(beat)); // R7
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !adv_n) |=> (beat == '0)); // R8
endmodule

// File: rtl/bac_seq_map.sv
`timescale 1ns/1ps
// Sequence mapper.
// Turns the start offset and the beat count into the low address bits, in
// either interleaved (XOR) or linear (add, wrap inside the aligned group) order.
// Assumes: order is static for the duration of a burst. This module is purely
// combinational.
module bac_seq_map
    import bac_pkg::*;
#(
    parameter int unsigned BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    input  burst_order_e      order,
    output logic [BEAT_W-1:0] addr_lo
);
    logic [BEAT_W-1:0] ilv_lo;
    logic [BEAT_W-1:0] lin_lo;

    // Interleaved order: flip each start bit where the beat bit is set.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv_bit
        assign ilv_lo[i] = start_lo[i] ^ beat[i];
    end

    // Linear order: the sum drops its carry, so the result wraps in the group.
    assign lin_lo = start_lo + beat;

    // Select the order given by the mode.
    always_comb begin
        addr_lo = (order == ORDER_INTERLEAVED) ? ilv_lo : lin_lo;
    end
endmodule

// File: rtl/burst_addr_counter.sv
`timescale 1ns/1ps
// Burst address counter (top).
// Loads an external start address, then steps the low BEAT_W bits through an
// interleaved or a linear order while the upper bits stay fixed. A load beats
// an advance; a high adv_n holds the current address.
// Assumes: ilv_mode is static; reset is synchronous, active low.
module burst_addr_counter
    import bac_pkg::*;
#(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              adv_n,
    input  logic              ilv_mode,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [BEAT_W-1:0] beat_idx
);
    localparam int unsigned HI_W = ADDR_W - BEAT_W;

    logic [HI_W-1:0]   base_hi;
    logic [BEAT_W-1:0] start_lo;
    logic [BEAT_W-1:0] addr_lo;
    burst_order_e      order;

    // Decode the mode pin into the order encoding.
    always_comb begin
        order = burst_order_e'(ilv_mode);
    end

    bac_addr_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_req),
        .ext_addr (ext_addr),
        .base_hi  (base_hi),
        .start_lo (start_lo)
    );

    bac_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_req),
        .adv_n (adv_n),
        .beat  (beat_idx)
    );

    bac_seq_map #(.BEAT_W(BEAT_W)) u_map (
        .start_lo (start_lo),
        .beat     (beat_idx),
        .order    (order),
        .addr_lo  (addr_lo)
    );

    // Join the fixed base and the stepped low bits.
    always_comb begin
        acc_addr = {base_hi, addr_lo};
    end

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_req && adv_n && $stable(ilv_mode)) |=> $stable(acc_addr)); // R7
    AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> (acc_addr == $past(ext_addr))); // R2
endmodule

// File: tb/tb_burst_addr_counter.sv
`timescale 1ns/1ps
module tb_burst_addr_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic        adv_n = 1'b1;
    logic        ilv_mode = 1'b1;
    logic [14:0] ext_addr = '0;
    logic [14:0] acc_addr;
    logic [1:0]  beat_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [14:0] m_addr = '0;
    logic [1:0]  m_beat = '0;

    always #2 clk = ~clk;

    burst_addr_counter dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .adv_n(adv_n),
        .ilv_mode(ilv_mode), .ext_addr(ext_addr), .acc_addr(acc_addr),
        .beat_idx(beat_idx)
    );

    function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] b,
                                           input logic ilv);
        return ilv ? (s ^ b) : 2'(s + b);
    endfunction

    function automatic logic [14:0] exp_addr();
        return {m_addr[14:2], exp_low(m_addr[1:0], m_beat, ilv_mode)};
    endfunction

    task automatic check(input string tag);
        logic [14:0] ea;
        ea = exp_addr();
        n_checks++;
        if (acc_addr !== ea || beat_idx !== m_beat) begin
            n_fail++;
            $display("FAIL %s: acc_addr=%h beat_idx=%0d expected %h/%0d",
                     tag, acc_addr, beat_idx, ea, m_beat);
        end
    endtask

    // One clock: drive at the falling edge, update the model, check after the edge.
    task automatic step(input logic rn, input logic ld, input logic an,
                        input logic [14:0] a, input string tag);
        @(negedge clk);
        rst_n = rn; start_req = ld; adv_n = an; ext_addr = a;
        @(posedge clk);
        if (!rn) begin
            m_addr = '0; m_beat = '0;
        end else if (ld) begin
            m_addr = a; m_beat = '0;
        end else if (!an) begin
            m_beat = m_beat + 2'd1;
        end
        #1;
        check(tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: acc_addr=%h beat_idx=%0d expected completion", acc_addr, beat_idx);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        step(1'b0, 1'b1, 1'b0, 15'h7FFF, "R1 reset");
        step(1'b0, 1'b0, 1'b1, 15'h0, "R1 reset");
        // Interleaved, start 01: expect 01,00,11,10 then wrap to 01.
        ilv_mode = 1'b1;
        step(1'b1, 1'b1, 1'b1, 15'h1235, "R2 load");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 15'h0, "R4 R6 interleaved");
        step(1'b1, 1'b0, 1'b1, 15'h7FFF, "R7 wait");
        step(1'b1, 1'b0, 1'b1, 15'h0, "R7 wait");
        // Interleaved, start 11.
        step(1'b1, 1'b1, 1'b1, 15'h7FFF, "R2 load");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 15'h0, "R3 R4 wrap");
        // Linear, start 10: expect 10,11,00,01 inside the group.
        ilv_mode = 1'b0;
        step(1'b1, 1'b1, 1'b1, 15'h4AAE, "R2 load");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 15'h0, "R5 R6 linear");
        step(1'b1, 1'b1, 1'b1, 15'h0003, "R2 load");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 15'h0, "R3 R5 no carry");
        // Load with advance active: load wins.
        step(1'b1, 1'b1, 1'b0, 15'h2221, "R8 load over advance");
        step(1'b1, 1'b0, 1'b0, 15'h0, "R5 linear");
        step(1'b0, 1'b0, 1'b0, 15'h0, "R1 reset mid-burst");
        // Random segments, each with a fixed mode.
        for (int seg = 0; seg < 20; seg++) begin
            @(negedge clk);
            ilv_mode = 1'($urandom);
            step(1'b1, 1'b1, 1'b1, 15'($urandom), "R2 segment load");
            for (int k = 0; k < 150; k++) begin
                logic ld, an;
                string tg;
                ld = ($urandom % 8) == 0;
                an = 1'($urandom);
                tg = ld ? (an ? "R2 load" : "R8 load over advance")
                        : (an ? "R7 wait" : (ilv_mode ? "R4 R6 random" : "R5 R6 random"));
                step(1'b1, ld, an, 15'($urandom), tg);
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule